// File: doc/BRIEF.md
# Dual I/O SPI Flash Read Responder

This block is the device side of a serial flash read path. The host lowers the select line and shifts an 8-bit read opcode in on SIO0. The block then moves to a two-wire bus and takes a 24-bit start address, followed by a mode byte and dummy clocks. After that it returns data from an internal pattern memory, two bits per clock, until the host raises select again.

A mode byte with bits [5:4] equal to `10` arms a continuous-read state. In that state the next transaction leaves out the opcode and starts directly with the address. Sixteen clocks with SIO0 held high clear that state. The number of dummy clocks is set by a 2-bit input that the host programs before the command. Everything in the block runs on SCK: inputs are sampled on the rising edge and outputs change on the falling edge.

The state machine has the states `ST_IDLE` (first clock after select falls), `ST_OPCODE`, `ST_ADDR`, `ST_DUMMY`, `ST_DATA` and `ST_REJECT`. Its transitions are:

- IDLE→OPCODE when continuous mode is off; IDLE→ADDR when it is on.
- OPCODE→ADDR on opcode 0xBB; OPCODE→REJECT on any other opcode.
- ADDR→DUMMY after 12 address pairs.
- DUMMY→DATA after the programmed number of dummy clocks.
- Any state→REJECT when the exit sequence completes.
- Any state→IDLE when select rises.

Top module: `dual_read_responder`

## Requirements
- R1: The first 8 rising edges after select falls sample the opcode on SIO0, most significant bit first. Only 0xBB starts a read. Any other opcode leaves SIO released until select rises.
- R2: The 24-bit address follows on 12 rising edges, most significant pair first, with SIO1 carrying the higher bit of each pair.
- R3: The dummy phase lasts 4 + 2×`dummy_sel` clocks (00→4, 01→6, 10→8, 11→10). Its first 4 clocks carry the mode byte as pairs M[7:6], M[5:4], M[3:2], M[1:0]. `sio_oe` stays 00 through the opcode, address and dummy phases.
- R4: On the falling edge after the last dummy clock, the block starts driving data with `sio_oe`=11. Each byte goes out most significant pair first, one pair per falling edge, with SIO1 carrying the higher bit.
- R5: The byte at address A is A[7:0] ^ A[15:8] ^ A[23:16] ^ 0xA5.
- R6: The address advances by one after each byte and wraps from 0xFFFFFF to 0x000000. Streaming continues for as long as select stays low.
- R7: If M[5:4] = 10, the next transaction omits the opcode and its first 12 clocks carry the address.
- R8: If M[5:4] has any other value, the next transaction must start with the opcode.
- R9: Sixteen consecutive rising edges with SIO0 = 1, counted from select falling, clear continuous mode. That transaction returns no data.
- R10: Raising select at any time sets `sio_oe` to 00 at once and returns the block to idle. Continuous mode keeps its value.
- R11: Asserting `rst_n` low sets `sio_oe` to 00 and clears continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| dummy_sel | input | 2 | Dummy-length setting |
| sio_in | input | 2 | Sampled bus lines, bit 1 = SIO1 |
| sio_out | output | 2 | Driven bus values |
| sio_oe | output | 2 | Per-line output enable |

## Verification
On every clock, the assertions check four things:
- `sio_oe` is 11 exactly while the sequencer is in its data phase, and is released while select is high.
- The pointer steps by one at each byte boundary.
- Continuous mode is set, dropped or held exactly as the captured mode pair and the exit sequence dictate.
- A rejected opcode stays rejected.

Only the bench scenarios can show the rest:
- the data values and bit order;
- the dummy length for each setting and the address wrap;
- whether an opcode-less transaction actually lands on the right address;
- that continuous mode survives an abort.

// File: rtl/dual_rd_pkg.sv
package dual_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_REJECT
    } rd_state_e;

    localparam logic [7:0] READ_OPCODE = 8'hBB;
    localparam int         MODE_CLKS   = 4;
    localparam logic [1:0] CONT_KEY    = 2'b10;
endpackage

// File: rtl/dual_rd_pattern.sv
module dual_rd_pattern #(
    parameter int         ADDR_W = 24,
    parameter logic [7:0] KEY    = 8'hA5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);
    localparam int LANES = ADDR_W / 8;

    // XOR-fold every address byte lane into the key
    always_comb begin
        data = KEY;
        for (int i = 0; i < LANES; i++) begin
            data = data ^ addr[8*i +: 8];
        end
    end
endmodule

// File: rtl/dual_rd_mode_ctl.sv
module dual_rd_mode_ctl #(
    parameter int EXIT_LEN = 16
) (
    input  logic       sck,
    input  logic       rst_n,
    input  logic       txn_rst_n,
    input  logic       sio0,
    input  logic       mode_cap_en,
    input  logic [1:0] mode_pair,
    output logic       cont_mode,
    output logic       reset_hit
);
    import dual_rd_pkg::*;

    localparam int RUN_W = $clog2(EXIT_LEN + 1);

    logic [RUN_W-1:0] ones_q;
    logic             run_ok_q;

    // run of ones on SIO0 since select fell
    always_ff @(posedge sck or negedge txn_rst_n) begin
        if (!txn_rst_n) begin
            ones_q   <= '0;
            run_ok_q <= 1'b1;
        end else if (!sio0) begin
            run_ok_q <= 1'b0;
        end else if (run_ok_q && ones_q != RUN_W'(EXIT_LEN)) begin
            ones_q <= ones_q + 1'b1;
        end
    end

    assign reset_hit = run_ok_q && sio0 && (ones_q == RUN_W'(EXIT_LEN - 1));

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            cont_mode <= 1'b0;
        end else if (reset_hit) begin
            cont_mode <= 1'b0;
        end else if (mode_cap_en) begin
            cont_mode <= (mode_pair == CONT_KEY);
        end
    end
endmodule

// File: rtl/dual_rd_seq.sv
module dual_rd_seq #(
    parameter int ADDR_W = 24
) (
    input  logic                    sck,
    input  logic                    txn_rst_n,
    input  logic [1:0]              sio_in,
    input  logic                    cont_mode,
    input  logic                    reset_hit,
    input  logic [1:0]              dummy_sel,
    output dual_rd_pkg::rd_state_e  state_q,
    output logic [1:0]              pair_idx,
    output logic [ADDR_W-1:0]       ptr_q,
    output logic                    mode_cap_en,
    output logic [1:0]              mode_pair
);
    import dual_rd_pkg::*;

    localparam int ADDR_PAIRS = ADDR_W / 2;
    localparam int CNT_W      = $clog2(ADDR_PAIRS + 1) + 1;
    localparam int OP_LAST    = 7;

    rd_state_e         state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-3:0] shreg_q;
    logic [CNT_W-1:0]  dummy_last;
    logic [7:0]        opcode_w;

    assign dummy_last = CNT_W'(MODE_CLKS - 1) + CNT_W'({dummy_sel, 1'b0});
    assign opcode_w   = {shreg_q[6:0], sio_in[0]};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = cont_mode ? ST_ADDR : ST_OPCODE;
            ST_OPCODE: if (cnt_q == CNT_W'(OP_LAST))
                           state_d = (opcode_w == READ_OPCODE) ? ST_ADDR : ST_REJECT;
            ST_ADDR:   if (cnt_q == CNT_W'(ADDR_PAIRS - 1)) state_d = ST_DUMMY;
            ST_DUMMY:  if (cnt_q == dummy_last) state_d = ST_DATA;
            ST_DATA:   state_d = ST_DATA;
            ST_REJECT: state_d = ST_REJECT;
            default:   state_d = ST_REJECT;
        endcase
        if (reset_hit) state_d = ST_REJECT;
    end

    // state register
    always_ff @(posedge sck or negedge txn_rst_n) begin
        if (!txn_rst_n) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // phase counter and input shifter
    always_ff @(posedge sck or negedge txn_rst_n) begin
        if (!txn_rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else begin
            if (state_q == ST_IDLE)       cnt_q <= CNT_W'(1);
            else if (state_d != state_q)  cnt_q <= '0;
            else                          cnt_q <= cnt_q + 1'b1;

            if ((state_q == ST_IDLE && !cont_mode) || state_q == ST_OPCODE)
                shreg_q <= {shreg_q[ADDR_W-4:0], sio_in[0]};
            else if (state_q == ST_IDLE || state_q == ST_ADDR)
                shreg_q <= {shreg_q[ADDR_W-5:0], sio_in};
        end
    end

    // address pointer
    always_ff @(posedge sck or negedge txn_rst_n) begin
        if (!txn_rst_n) begin
            ptr_q <= '0;
        end else if (state_q == ST_ADDR && state_d == ST_DUMMY) begin
            ptr_q <= {shreg_q, sio_in};
        end else if (state_q == ST_DATA && cnt_q[1:0] == 2'd3) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign pair_idx    = cnt_q[1:0];
    assign mode_cap_en = (state_q == ST_DUMMY) && (cnt_q == CNT_W'(1));
    assign mode_pair   = sio_in;
endmodule

// File: rtl/dual_rd_drive.sv
module dual_rd_drive #(
    parameter int         ADDR_W = 24,
    parameter logic [7:0] KEY    = 8'hA5
) (
    input  logic                   sck,
    input  logic                   txn_rst_n,
    input  dual_rd_pkg::rd_state_e state_q,
    input  logic [1:0]             pair_idx,
    input  logic [ADDR_W-1:0]      ptr_q,
    output logic [1:0]             sio_out,
    output logic [1:0]             sio_oe
);
    import dual_rd_pkg::*;

    logic [7:0] rd_byte;
    logic [1:0] pair_w;

    dual_rd_pattern #(.ADDR_W(ADDR_W), .KEY(KEY)) u_pattern (
        .addr (ptr_q),
        .data (rd_byte)
    );

    always_comb begin
        unique case (pair_idx)
            2'd0:    pair_w = rd_byte[7:6];
            2'd1:    pair_w = rd_byte[5:4];
            2'd2:    pair_w = rd_byte[3:2];
            default: pair_w = rd_byte[1:0];
        endcase
    end

    // outputs change on the falling edge
    always_ff @(negedge sck or negedge txn_rst_n) begin
        if (!txn_rst_n) begin
            sio_out <= 2'b00;
            sio_oe  <= 2'b00;
        end else if (state_q == ST_DATA) begin
            sio_out <= pair_w;
            sio_oe  <= 2'b11;
        end else begin
            sio_out <= 2'b00;
            sio_oe  <= 2'b00;
        end
    end
endmodule

// File: rtl/dual_read_responder.sv
module dual_read_responder #(
    parameter int         ADDR_W   = 24,
    parameter logic [7:0] KEY      = 8'hA5,
    parameter int         EXIT_LEN = 16
) (
    input  logic       sck,
    input  logic       rst_n,
    input  logic       sel_n,
    input  logic [1:0] dummy_sel,
    input  logic [1:0] sio_in,
    output logic [1:0] sio_out,
    output logic [1:0] sio_oe
);
    import dual_rd_pkg::*;

    logic              txn_rst_n;
    rd_state_e         state_q;
    logic [1:0]        pair_idx;
    logic [ADDR_W-1:0] ptr_q;
    logic              mode_cap_en;
    logic [1:0]        mode_pair;
    logic              cont_mode;
    logic              reset_hit;

    // select high or global reset clears the transaction
    assign txn_rst_n = rst_n & ~sel_n;

    dual_rd_mode_ctl #(.EXIT_LEN(EXIT_LEN)) u_mode (
        .sck         (sck),
        .rst_n       (rst_n),
        .txn_rst_n   (txn_rst_n),
        .sio0        (sio_in[0]),
        .mode_cap_en (mode_cap_en),
        .mode_pair   (mode_pair),
        .cont_mode   (cont_mode),
        .reset_hit   (reset_hit)
    );

    dual_rd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .sck         (sck),
        .txn_rst_n   (txn_rst_n),
        .sio_in      (sio_in),
        .cont_mode   (cont_mode),
        .reset_hit   (reset_hit),
        .dummy_sel   (dummy_sel),
        .state_q     (state_q),
        .pair_idx    (pair_idx),
        .ptr_q       (ptr_q),
        .mode_cap_en (mode_cap_en),
        .mode_pair   (mode_pair)
    );

    dual_rd_drive #(.ADDR_W(ADDR_W), .KEY(KEY)) u_drive (
        .sck       (sck),
        .txn_rst_n (txn_rst_n),
        .state_q   (state_q),
        .pair_idx  (pair_idx),
        .ptr_q     (ptr_q),
        .sio_out   (sio_out),
        .sio_oe    (sio_oe)
    );
endmodule

// File: rtl/dual_read_responder_chk.sv
module dual_read_responder_chk #(
    parameter int ADDR_W = 24
) (
    input logic                   sck,
    input logic                   rst_n,
    input logic                   sel_n,
    input logic [1:0]             sio_oe,
    input dual_rd_pkg::rd_state_e state_q,
    input logic [1:0]             pair_idx,
    input logic [ADDR_W-1:0]      ptr_q,
    input logic                   cont_mode,
    input logic                   reset_hit,
    input logic                   mode_cap_en,
    input logic [1:0]             mode_pair
);
    import dual_rd_pkg::*;

    AST_OE_DATA_ONLY: assert property (@(posedge sck) disable iff (!rst_n || sel_n)
        (sio_oe == 2'b11) == (state_q == ST_DATA)); // R3

    AST_OE_ALL_OR_NONE: assert property (@(posedge sck) disable iff (!rst_n)
        (sio_oe == 2'b00) || (sio_oe == 2'b11)); // R4

    AST_DESELECT_RELEASE: assert property (@(posedge sck) disable iff (!rst_n)
        sel_n |-> (sio_oe == 2'b00)); // R10

    AST_PTR_STEP: assert property (@(posedge sck) disable iff (!rst_n || sel_n)
        (state_q == ST_DATA && pair_idx == 2'd3) |=>
        (ptr_q == ($past(ptr_q) + {{(ADDR_W-1){1'b0}}, 1'b1}))); // R6

    AST_CONT_ARM: assert property (@(posedge sck) disable iff (!rst_n)
        (mode_cap_en && mode_pair == CONT_KEY && !reset_hit) |=> cont_mode); // R7

    AST_CONT_DROP: assert property (@(posedge sck) disable iff (!rst_n)
        (mode_cap_en && mode_pair != CONT_KEY) |=> !cont_mode); // R8

    AST_EXIT_CLEARS: assert property (@(posedge sck) disable iff (!rst_n)
        reset_hit |=> !cont_mode); // R9

    AST_EXIT_NO_DATA: assert property (@(posedge sck) disable iff (!rst_n || sel_n)
        reset_hit |=> (state_q == ST_REJECT)); // R9

    AST_CONT_HOLD: assert property (@(posedge sck) disable iff (!rst_n)
        (!mode_cap_en && !reset_hit) |=> $stable(cont_mode)); // R10

    AST_REJECT_STICKY: assert property (@(posedge sck) disable iff (!rst_n || sel_n)
        (state_q == ST_REJECT) |=> (state_q == ST_REJECT)); // R1
endmodule

bind dual_read_responder dual_read_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .sck         (sck),
    .rst_n       (rst_n),
    .sel_n       (sel_n),
    .sio_oe      (sio_oe),
    .state_q     (state_q),
    .pair_idx    (pair_idx),
    .ptr_q       (ptr_q),
    .cont_mode   (cont_mode),
    .reset_hit   (reset_hit),
    .mode_cap_en (mode_cap_en),
    .mode_pair   (mode_pair)
);

// File: tb/test_dual_read_responder.sv
module test_dual_read_responder;
    timeunit 1ns;
    timeprecision 1ps;

    logic       sck = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic [1:0] dummy_sel = 2'b00;
    logic [1:0] sio_in = 2'b00;
    wire  [1:0] sio_out;
    wire  [1:0] sio_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  pending_fall = 1'b0;
    bit  hdr_quiet;
    bit  cont_exp = 1'b0;

    dual_read_responder i_dual_read_responder (
        .sck       (sck),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .dummy_sel (dummy_sel),
        .sio_in    (sio_in),
        .sio_out   (sio_out),
        .sio_oe    (sio_oe)
    );

    always #2ns sck = ~sck;

    function automatic logic [7:0] exp_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one host clock: change inputs on the falling edge
    task automatic put(input logic [1:0] v);
        @(negedge sck);
        if (pending_fall) begin
            sel_n = 1'b0;
            pending_fall = 1'b0;
        end
        sio_in = v;
        #1ns;
        if (sio_oe != 2'b00) hdr_quiet = 1'b0;
    endtask

    task automatic header(input bit with_op, input logic [7:0] op, input logic [23:0] addr,
                          input logic [7:0] mode, input logic [1:0] cfg);
        dummy_sel    = cfg;
        hdr_quiet    = 1'b1;
        pending_fall = 1'b1;
        if (with_op)
            for (int i = 7; i >= 0; i--) put({1'b0, op[i]});
        for (int i = 11; i >= 0; i--) put(addr[2*i +: 2]);
        for (int k = 0; k < 4 + 2 * int'(cfg); k++)
            put(k < 4 ? mode[7-2*k -: 2] : 2'b00);
    endtask

    task automatic read_bytes(input int n, input logic [23:0] start, input string req);
        logic [7:0]  got;
        logic [23:0] a;
        bit          oe_ok;
        a = start;
        for (int b = 0; b < n; b++) begin
            got   = '0;
            oe_ok = 1'b1;
            for (int p = 0; p < 4; p++) begin
                @(negedge sck);
                sio_in = 2'b00;
                #1ns;
                if (sio_oe != 2'b11) oe_ok = 1'b0;
                got = {got[5:0], sio_out};
            end
            check(oe_ok && got == exp_byte(a), req, {23'd0, oe_ok, got}, {24'd1, exp_byte(a)});
            a = a + 24'd1;
        end
    endtask

    task automatic deselect();
        @(negedge sck);
        sel_n = 1'b1;
        #1ns;
        check(sio_oe == 2'b00, "R10 release on deselect", 32'(sio_oe), 32'd0);
        repeat (2) @(negedge sck);
    endtask

    task automatic read_txn(input logic [23:0] addr, input logic [7:0] mode,
                            input logic [1:0] cfg, input int n, input string req);
        header(!cont_exp, 8'hBB, addr, mode, cfg);
        check(hdr_quiet, "R3 bus released before data", 32'(hdr_quiet), 32'd1);
        read_bytes(n, addr, req);
        deselect();
        cont_exp = (mode[5:4] == 2'b10);
    endtask

    task automatic exit_seq();
        hdr_quiet    = 1'b1;
        pending_fall = 1'b1;
        for (int i = 0; i < 16; i++) put(2'b01);
        for (int i = 0; i < 6; i++) put(2'b00);
        check(hdr_quiet, "R9 no data in exit sequence", 32'(hdr_quiet), 32'd1);
        deselect();
        cont_exp = 1'b0;
    endtask

    initial begin
        #600us;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] a;
        logic [7:0]  m;
        logic [1:0]  c;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge sck);
        #1ns;
        check(sio_oe == 2'b00, "R11 reset releases bus", 32'(sio_oe), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge sck);

        // R1 R2 R4 R5: plain read, each dummy setting (R3)
        read_txn(24'h123456, 8'h00, 2'b00, 4, "R4 R5 data cfg00");
        read_txn(24'hABCDE0, 8'h00, 2'b01, 3, "R3 data cfg01");
        read_txn(24'h00F00D, 8'h00, 2'b10, 3, "R3 data cfg10");
        read_txn(24'h7A5A10, 8'hFF, 2'b11, 3, "R3 data cfg11");

        // R6 wrap at top of address space
        read_txn(24'hFFFFFE, 8'h00, 2'b01, 4, "R6 wrap to zero");

        // R1 wrong opcode: no drive while select stays low
        header(1'b1, 8'h3B, 24'h000100, 8'h00, 2'b00);
        hdr_quiet = 1'b1;
        for (int i = 0; i < 24; i++) put(2'b00);
        check(hdr_quiet, "R1 wrong opcode ignored", 32'(hdr_quiet), 32'd1);
        deselect();

        // R7 continuous mode then opcode-less read; R8 dropping it
        read_txn(24'h010203, 8'h20, 2'b00, 2, "R7 arm cont");
        read_txn(24'h3C3C3C, 8'hA0, 2'b01, 3, "R7 opcode-less read");
        read_txn(24'h445566, 8'h30, 2'b00, 2, "R7 last opcode-less read");
        read_txn(24'h778899, 8'h00, 2'b10, 2, "R8 opcode required again");

        // R10 abort mid address keeps continuous mode
        read_txn(24'h202020, 8'h20, 2'b00, 1, "R10 arm cont");
        pending_fall = 1'b1;
        for (int i = 0; i < 5; i++) put(2'b10);
        deselect();
        read_txn(24'h5A0F00, 8'h00, 2'b00, 2, "R10 cont kept after abort");

        // R10 abort mid data
        header(1'b1, 8'hBB, 24'h000040, 8'h00, 2'b00);
        repeat (6) @(negedge sck);
        deselect();

        // R9 exit sequence clears continuous mode
        read_txn(24'h0A0B0C, 8'h20, 2'b00, 1, "R9 arm cont");
        exit_seq();
        read_txn(24'h112233, 8'h00, 2'b01, 2, "R9 opcode read after exit");

        // R11 reset clears continuous mode
        read_txn(24'h0F0F00, 8'h20, 2'b00, 1, "R11 arm cont");
        @(negedge sck);
        rst_n = 1'b0;
        @(negedge sck);
        rst_n = 1'b1;
        cont_exp = 1'b0;
        read_txn(24'h654320, 8'h00, 2'b11, 2, "R11 opcode read after reset");

        // constrained random mix
        for (int t = 0; t < 14; t++) begin
            a = 24'($urandom) & 24'hFFFFFE;
            c = 2'($urandom);
            m = ($urandom % 2 == 0) ? 8'h20 : 8'($urandom);
            read_txn(a, m, c, 1 + int'($urandom % 5), "R2 R5 R7 random read");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule